// File: doc/BRIEF.md
# Barrel-Threaded Instruction Issue Scheduler

This block picks, in every cycle, the hardware thread that may send one instruction into a pipeline shared by all threads of a core. Software and the thread-control logic provide two masks with one bit per thread. The active mask marks the threads that exist. The ready mask falls while a thread is blocked, for example while it waits on I/O. The scheduler returns an issue-valid flag and the index of the chosen thread. It also keeps a record of which threads still have an instruction somewhere in the pipeline.

A thread may have only one instruction in flight at a time. It therefore cannot issue again until its previous instruction has left the last pipeline stage. With the default depth of four, this caps any thread at one slot in four. When four or fewer threads run, each gets exactly one cycle in four and the remaining cycles are idle. With more threads than stages, the threads share the slots in a rotating order. A thread that is blocked gives up its turns to any other thread that can use them.

The decision is combinational from the two masks and the registered scheduling state. The chosen index sits in the same cycle as the masks that produced it. The instruction datapath, decode, register files and the I/O event logic all lie outside the block.

Top module: `barrel_issue_sched`

## Requirements
- R1: While reset is high, issue_valid is 0 and inflight_mask is all zeros. After reset the rotation pointer is 0, so with every thread active and ready, the first issue goes to thread 0.
- R2: A thread is issued only when its bit is set in thread_active and in thread_ready, and it has no instruction in flight.
- R3: A thread is never issued twice within PIPE_DEPTH consecutive cycles.
- R4: The chosen thread is the first eligible one in ascending cyclic order, counting from the rotation pointer. After an issue, the pointer becomes the issued index plus one, modulo THREADS.
- R5: With n active and always-ready threads, where n is at most PIPE_DEPTH, each thread issues exactly once every PIPE_DEPTH cycles. The other PIPE_DEPTH minus n cycles of each period are idle.
- R6: With n active and always-ready threads, where n is greater than PIPE_DEPTH, each thread issues exactly once every n cycles and no cycle is idle.
- R7: If any thread is eligible, issue_valid is 1 in that cycle. The slots of a blocked thread go to the other eligible threads.
- R8: In a cycle with no eligible thread, issue_valid is 0, issue_tid is 0, and the rotation pointer keeps its value.
- R9: Clearing a thread's active bit does not cancel its in-flight instruction. The instruction's inflight_mask bit still ages out normally, and the thread is not issued again while its active bit is low.
- R10: Bit t of inflight_mask is 1 for the PIPE_DEPTH-1 cycles that follow each cycle in which thread t issues, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thread_active | input | THREADS | Per-thread active mask |
| thread_ready | input | THREADS | Per-thread ready mask (low while blocked) |
| issue_valid | output | 1 | A thread issues in this cycle |
| issue_tid | output | clog2(THREADS) | Index of the issuing thread (0 when none) |
| inflight_mask | output | THREADS | Threads that have an instruction in pipeline stages after issue |

## Verification
The bench builds the block with eight threads and a depth of four. This covers every active-thread count from one to eight, on both sides of the boundary where the thread count equals the depth. For each count, the bench runs a window of 840 cycles, the least common multiple of one through eight, starting from reset. Every thread's issue count must then come out exact, not just at or above a minimum. Random mask sequences, fully blocked stretches and mid-flight deactivation exercise the rotation pointer, the hold of the pointer on idle cycles, and the ageing of the in-flight record.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int unsigned DEF_THREADS    = 8;
    localparam int unsigned DEF_PIPE_DEPTH = 4;

    // Width of a thread index for a given thread count.
    function automatic int unsigned tid_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Cyclic index: (base + off) modulo n.
    function automatic int unsigned wrap_idx(input int unsigned base,
                                             input int unsigned off,
                                             input int unsigned n);
        return (base + off) % n;
    endfunction

endpackage

// File: rtl/sched_elig.sv
module sched_elig
    import sched_pkg::*;
#(
    parameter int unsigned THREADS = DEF_THREADS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [THREADS-1:0] active,
    input  logic [THREADS-1:0] ready,
    input  logic [THREADS-1:0] busy,
    output logic [THREADS-1:0] elig
);

    always_comb begin
        for (int t = 0; t < THREADS; t++) begin
            elig[t] = active[t] & ready[t] & ~busy[t];
        end
    end

    // R2: no thread that is busy in the pipeline is ever offered
    assert_busy_excluded_R2: assert property (@(posedge clk) disable iff (rst)
        (elig & busy) == '0);

endmodule

// File: rtl/sched_rr_arb.sv
module sched_rr_arb
    import sched_pkg::*;
#(
    parameter int unsigned THREADS = DEF_THREADS,
    localparam int unsigned TID_W  = tid_width(THREADS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [THREADS-1:0] elig,
    output logic               grant_vld,
    output logic [TID_W-1:0]   grant_tid
);

    typedef struct packed {
        logic             found;
        logic [TID_W-1:0] tid;
    } pick_t;

    logic [TID_W-1:0] ptr_q;
    pick_t            pick;

    // Scan from the highest offset down, so that the lowest offset wins.
    always_comb begin
        pick = '0;
        for (int i = THREADS - 1; i >= 0; i--) begin
            int unsigned idx;
            idx = wrap_idx(int'(ptr_q), i, THREADS);
            if (elig[idx]) begin
                pick.found = 1'b1;
                pick.tid   = TID_W'(idx);
            end
        end
    end

    assign grant_vld = pick.found & ~rst;
    assign grant_tid = grant_vld ? pick.tid : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (grant_vld) begin
            ptr_q <= TID_W'(wrap_idx(int'(grant_tid), 1, THREADS));
        end
    end

    // R4: the thread under the pointer wins whenever it is eligible
    assert_ptr_priority_R4: assert property (@(posedge clk) disable iff (rst)
        elig[ptr_q] |-> (grant_vld && grant_tid == ptr_q));

    // R4: after an issue, the pointer moves past the issued thread
    assert_ptr_advance_R4: assert property (@(posedge clk) disable iff (rst)
        grant_vld |=> (ptr_q == TID_W'(wrap_idx(int'($past(grant_tid)), 1, THREADS))));

    // R8: idle cycles leave the pointer untouched
    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !grant_vld |=> $stable(ptr_q));

    // R4: the pointer stays inside the thread range
    assert_ptr_range_R4: assert property (@(posedge clk) disable iff (rst)
        int'(ptr_q) < THREADS);

endmodule

// File: rtl/sched_inflight.sv
module sched_inflight
    import sched_pkg::*;
#(
    parameter int unsigned THREADS    = DEF_THREADS,
    parameter int unsigned PIPE_DEPTH = DEF_PIPE_DEPTH,
    localparam int unsigned TID_W     = tid_width(THREADS),
    localparam int unsigned SLOTS     = (PIPE_DEPTH > 1) ? PIPE_DEPTH - 1 : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_vld,
    input  logic [TID_W-1:0]   issue_tid,
    output logic [THREADS-1:0] busy
);

    typedef struct packed {
        logic             vld;
        logic [TID_W-1:0] tid;
    } slot_t;

    slot_t stage_q [SLOTS];

    generate
        if (PIPE_DEPTH > 1) begin : g_track
            for (genvar s = 0; s < SLOTS; s++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst) begin
                        stage_q[s] <= '0;
                    end else if (s == 0) begin
                        stage_q[s] <= '{vld: issue_vld, tid: issue_tid};
                    end else begin
                        stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                    end
                end
            end

            always_comb begin
                busy = '0;
                for (int s = 0; s < SLOTS; s++) begin
                    if (stage_q[s].vld) begin
                        busy[stage_q[s].tid] = 1'b1;
                    end
                end
            end
        end else begin : g_none
            always_ff @(posedge clk) begin
                stage_q[0] <= '0;
            end
            assign busy = '0;
        end
    endgenerate

    // R3: an issuing thread has nothing in flight
    assert_single_in_flight_R3: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> !busy[issue_tid]);

    // R10: the issued thread is marked in flight on the next cycle
    assert_mark_after_issue_R10: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && PIPE_DEPTH > 1) |=> busy[$past(issue_tid)]);

    // R10: at most one thread per post-issue stage
    assert_busy_bound_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(busy) <= SLOTS);

endmodule

// File: rtl/barrel_issue_sched.sv
module barrel_issue_sched
    import sched_pkg::*;
#(
    parameter int unsigned THREADS    = DEF_THREADS,
    parameter int unsigned PIPE_DEPTH = DEF_PIPE_DEPTH,
    localparam int unsigned TID_W     = tid_width(THREADS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [THREADS-1:0] thread_active,
    input  logic [THREADS-1:0] thread_ready,
    output logic               issue_valid,
    output logic [TID_W-1:0]   issue_tid,
    output logic [THREADS-1:0] inflight_mask
);

    logic [THREADS-1:0] busy;
    logic [THREADS-1:0] elig;

    sched_elig #(.THREADS(THREADS)) u_elig (
        .clk    (clk),
        .rst    (rst),
        .active (thread_active),
        .ready  (thread_ready),
        .busy   (busy),
        .elig   (elig)
    );

    sched_rr_arb #(.THREADS(THREADS)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .elig      (elig),
        .grant_vld (issue_valid),
        .grant_tid (issue_tid)
    );

    sched_inflight #(.THREADS(THREADS), .PIPE_DEPTH(PIPE_DEPTH)) u_track (
        .clk       (clk),
        .rst       (rst),
        .issue_vld (issue_valid),
        .issue_tid (issue_tid),
        .busy      (busy)
    );

    assign inflight_mask = busy;

    // R2: only active and ready threads issue
    assert_issue_allowed_R2: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (thread_active[issue_tid] && thread_ready[issue_tid]));

    // R7: no slot is wasted while some thread could use it
    assert_work_conserving_R7: assert property (@(posedge clk) disable iff (rst)
        ((thread_active & thread_ready & ~inflight_mask) != '0) |-> issue_valid);

    // R8: the index reads zero in idle cycles
    assert_idle_tid_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |-> (issue_tid == '0));

    // R1: reset clears the in-flight record
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (inflight_mask == '0));

endmodule

// File: tb/sim_barrel_issue_sched.sv
module sim_barrel_issue_sched;

    localparam int N = 8;
    localparam int D = 4;
    localparam int W = 3;
    localparam int WINDOW = 840;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] act = '0;
    logic [N-1:0] rdy = '0;
    logic         issue_valid;
    logic [W-1:0] issue_tid;
    logic [N-1:0] inflight_mask;

    always #5 clk = ~clk;

    barrel_issue_sched #(.THREADS(N), .PIPE_DEPTH(D)) u0 (
        .clk           (clk),
        .rst           (rst),
        .thread_active (act),
        .thread_ready  (rdy),
        .issue_valid   (issue_valid),
        .issue_tid     (issue_tid),
        .inflight_mask (inflight_mask)
    );

    typedef struct {
        logic         vld;
        logic [W-1:0] tid;
        logic [N-1:0] busy;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    // reference model state
    int   ptr_m;
    logic hv [D-1];
    int   ht [D-1];
    int   cnt [N];
    int   last_iss [N];
    int   cyc = 0;

    task automatic model_clear();
        ptr_m = 0;
        for (int s = 0; s < D - 1; s++) begin hv[s] = 0; ht[s] = 0; end
        for (int t = 0; t < N; t++) begin cnt[t] = 0; last_iss[t] = -100; end
    endtask

    task automatic step(input logic [N-1:0] a, input logic [N-1:0] r, input string tag);
        exp_t         e;
        logic [N-1:0] bm;
        logic [N-1:0] el;
        @(posedge clk);
        #1;
        act = a;
        rdy = r;
        bm = '0;
        for (int s = 0; s < D - 1; s++) if (hv[s]) bm[ht[s]] = 1'b1;
        el = a & r & ~bm;
        e.vld = 0; e.tid = '0; e.busy = bm; e.tag = tag;
        for (int i = 0; i < N; i++) begin
            int idx = (ptr_m + i) % N;
            if (!e.vld && el[idx]) begin e.vld = 1; e.tid = W'(idx); end
        end
        q.push_back(e);
        for (int s = D - 2; s > 0; s--) begin hv[s] = hv[s-1]; ht[s] = ht[s-1]; end
        hv[0] = e.vld;
        ht[0] = int'(e.tid);
        if (e.vld) ptr_m = (int'(e.tid) + 1) % N;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1;
        act = '1;
        rdy = '1;
        repeat (2) @(posedge clk);
        #1;
        checks++;
        if (issue_valid !== 1'b0 || inflight_mask !== '0) begin
            fails++;
            $display("FAIL R1 during reset: valid=%b mask=%b expected valid=0 mask=0",
                     issue_valid, inflight_mask);
        end
        rst = 0;
        act = '0;
        rdy = '0;
        model_clear();
    endtask

    // monitor: pops expectations and compares them against the outputs
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cyc++;
            checks++;
            if (issue_valid !== e.vld || (e.vld && issue_tid !== e.tid)
                || (!e.vld && issue_tid !== '0)) begin
                fails++;
                $display("FAIL %s R4 R7 R8 pick: valid=%b tid=%0d expected valid=%b tid=%0d",
                         e.tag, issue_valid, issue_tid, e.vld, e.tid);
            end
            checks++;
            if (inflight_mask !== e.busy) begin
                fails++;
                $display("FAIL %s R10 inflight: %b expected %b", e.tag, inflight_mask, e.busy);
            end
            if (issue_valid === 1'b1) begin
                checks++;
                if (cyc - last_iss[issue_tid] < D) begin
                    fails++;
                    $display("FAIL R3 spacing: thread %0d gap %0d expected >= %0d",
                             issue_tid, cyc - last_iss[issue_tid], D);
                end
                last_iss[issue_tid] = cyc;
                cnt[issue_tid]++;
            end
        end
    end

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 10 - 100);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_clear();

        // R1: reset state, then the first issue goes to thread 0
        do_reset();
        step('1, '1, "R1");
        drain();
        checks++;
        if (last_iss[0] != cyc) begin
            fails++;
            $display("FAIL R1 first issue: thread0 last=%0d expected %0d", last_iss[0], cyc);
        end

        // R5 and R6: exact shares for every thread count
        for (int n = 1; n <= N; n++) begin
            logic [N-1:0] m;
            m = N'((1 << n) - 1);
            do_reset();
            for (int k = 0; k < WINDOW; k++) step(m, m, (n <= D) ? "R5" : "R6");
            drain();
            for (int t = 0; t < N; t++) begin
                int expc;
                expc = (t >= n) ? 0 : ((n <= D) ? WINDOW / D : WINDOW / n);
                checks++;
                if (cnt[t] != expc) begin
                    fails++;
                    if (n <= D)
                        $display("FAIL R5 n=%0d thread %0d count %0d expected %0d", n, t, cnt[t], expc);
                    else
                        $display("FAIL R6 n=%0d thread %0d count %0d expected %0d", n, t, cnt[t], expc);
                end
            end
        end

        // R7: one of six active threads blocked, the other five share its slots
        do_reset();
        for (int k = 0; k < 500; k++) step(8'h3F, 8'h1F, "R7");
        drain();
        for (int t = 0; t < 6; t++) begin
            checks++;
            if (cnt[t] != ((t == 5) ? 0 : 100)) begin
                fails++;
                $display("FAIL R7 thread %0d count %0d expected %0d", t, cnt[t], (t == 5) ? 0 : 100);
            end
        end

        // R2: all active, readiness toggles
        do_reset();
        for (int k = 0; k < 400; k++) step('1, N'($urandom), "R2");

        // R8: nothing eligible, then the held pointer picks next
        do_reset();
        step(8'hFF, 8'hFF, "R8");
        step(8'hFF, 8'hFF, "R8");
        step(8'hFF, 8'hFF, "R8");
        for (int k = 0; k < 6; k++) step(8'hFF, 8'h00, "R8");
        for (int k = 0; k < 8; k++) step(8'hFF, 8'hFF, "R8");

        // R9: deactivate a thread whose instruction is still in flight
        do_reset();
        step(8'h0F, 8'h0F, "R9");
        step(8'h0F, 8'h0F, "R9");
        for (int k = 0; k < 20; k++) step(8'h0D, 8'h0F, "R9");
        drain();
        checks++;
        if (cnt[1] != 1) begin
            fails++;
            $display("FAIL R9 deactivated thread issued %0d times expected 1", cnt[1]);
        end

        // R4: random masks exercise the rotation
        do_reset();
        for (int k = 0; k < 3000; k++) step(N'($urandom), N'($urandom | $urandom), "R4");
        drain();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule